// File: doc/BRIEF.md
# Quad-Channel Parallel DAC Code Loader

This block is the digital front end for four 14-bit converter channels that are fed from a parallel microprocessor bus. A host drives a chip select and a write strobe. A write is committed when the strobe returns high while the chip select is low. A 3-bit channel address picks one of four input registers. A data word can arrive in two ways. In word mode it is a single 14-bit value. In byte mode it arrives as two right-justified writes: a low byte that carries bits 7:0 and a high byte that carries bits 13:8. The high-byte write completes the word.

Each channel has a second stage, its DAC latch, which holds the code the converter is driving. It also has an output-select flag. A flag value of 1 means the output shows the latched code. A flag value of 0 means the output shows the external sense-ground level. A level-sensitive, active-low load input copies the input registers into the latches. An asynchronous active-low clear switches every output to sense ground and keeps it there until a later load.

Top module: `dac_loader`

## Requirements
- R1: After reset every latched code is 0 and every output-select flag is 0.
- R2: In word mode (`byte_mode_i`=0), a write commits `data_i[13:0]` to the input register of the channel named by `addr_i`. The commit happens on the clock edge at which `wr_ni` is seen high after being low, while `cs_ni` is low.
- R3: A strobe that returns high while `cs_ni` is high changes no register.
- R4: In byte mode (`byte_mode_i`=1), a write with `byte_hi_i`=0 stages `data_i[7:0]` as bits 7:0 and leaves the input register unchanged. A write with `byte_hi_i`=1 stores `data_i[5:0]` as bits 13:8 together with that channel's staged low byte. Each channel keeps its own staged byte.
- R5: Writes to channel addresses 4 to 7 change no register.
- R6: While `load_ni` is high, latched codes and flags do not change.
- R7: While `load_ni` is low and `clr_ni` is high, every latch takes its input register on each clock edge and every flag is set to 1.
- R8: While `clr_ni` is low, all flags are 0 without waiting for a clock, and `load_ni` has no effect on the latches.
- R9: After `clr_ni` returns high, the flags stay 0 until `load_ni` is seen low.
- R10: With `load_ni` held low, the addressed latch shows newly completed data one clock after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Write strobe, active low, commits on its rise |
| byte_mode_i | input | 1 | 0: 14-bit word writes, 1: two-byte writes |
| byte_hi_i | input | 1 | In byte mode, 1 selects the high part |
| addr_i | input | 3 | Channel address |
| data_i | input | 14 | Write data, right-justified |
| load_ni | input | 1 | Level-sensitive load, active low |
| clr_ni | input | 1 | Asynchronous clear to sense ground, active low |
| code_o | output | 56 | Four latched codes, channel i at bits 14*i+13:14*i |
| use_dac_o | output | 4 | Per-channel flag: 1 selects the code, 0 selects sense ground |

## Verification
The bench uses the default parameters: four channels, a 14-bit code, an 8-bit low part and a 3-bit address. This leaves addresses 4 to 7 decoded but unused, so the ignored-address case can be exercised. The 8/6 split means that high-byte bits 7:6 are don't-care and must not leak into the stored code. The vector walk keeps load low so that every write shows up at the outputs one cycle later. Directed steps then cover held load, a de-selected strobe, and clear with its release sequence.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WORD = 2'd1,
    OP_LO   = 2'd2,
    OP_HI   = 2'd3
  } wr_op_e;
endpackage

// File: rtl/dac_bus_capture.sv
module dac_bus_capture
  import dac_loader_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              byte_mode_i,
  input  logic              byte_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_op_e            op_o,
  output logic [NCH-1:0]    sel_o
);
  logic wr_q;
  logic commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign commit = wr_ni & ~wr_q & ~cs_ni;

  always_comb begin
    if (!commit)          op_o = OP_NONE;
    else if (!byte_mode_i) op_o = OP_WORD;
    else if (byte_hi_i)    op_o = OP_HI;
    else                   op_o = OP_LO;
  end

  // out-of-range addresses select nothing
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign sel_o[i] = commit && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_loader_pkg::*;
#(
  parameter int DW   = 14,
  parameter int LO_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_ni,
  input  logic          sel_i,
  input  wr_op_e        op_i,
  input  logic [DW-1:0] data_i,
  input  logic          load_ni,
  output logic [DW-1:0] code_o,
  output logic          use_dac_o
);
  localparam int HI_W = DW - LO_W;

  logic [LO_W-1:0] lo_stage;
  logic [DW-1:0]   in_reg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_stage <= '0;
      in_reg   <= '0;
    end else if (sel_i) begin
      unique case (op_i)
        OP_WORD: in_reg   <= data_i;
        OP_LO:   lo_stage <= data_i[LO_W-1:0];
        OP_HI:   in_reg   <= {data_i[HI_W-1:0], lo_stage};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                code_o <= '0;
    else if (clr_ni && !load_ni) code_o <= in_reg;
  end

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni)       use_dac_o <= 1'b0;
    else if (!clr_ni)  use_dac_o <= 1'b0;
    else if (!load_ni) use_dac_o <= 1'b1;
  end
endmodule

// File: rtl/dac_loader.sv
module dac_loader
  import dac_loader_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 14,
  parameter int LO_W   = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              byte_mode_i,
  input  logic              byte_hi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              load_ni,
  input  logic              clr_ni,
  output logic [NCH*DW-1:0] code_o,
  output logic [NCH-1:0]    use_dac_o
);
  wr_op_e         op;
  logic [NCH-1:0] sel;

  dac_bus_capture #(.NCH(NCH), .ADDR_W(ADDR_W)) cap_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .wr_ni       (wr_ni),
    .byte_mode_i (byte_mode_i),
    .byte_hi_i   (byte_hi_i),
    .addr_i      (addr_i),
    .op_o        (op),
    .sel_o       (sel)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_chan #(.DW(DW), .LO_W(LO_W)) ch_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_ni    (clr_ni),
      .sel_i     (sel[i]),
      .op_i      (op),
      .data_i    (data_i),
      .load_ni   (load_ni),
      .code_o    (code_o[i*DW +: DW]),
      .use_dac_o (use_dac_o[i])
    );
  end
endmodule

// File: rtl/dac_loader_chk.sv
module dac_loader_chk #(
  parameter int NCH = 4,
  parameter int DW  = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_ni,
  input logic              clr_ni,
  input logic [NCH*DW-1:0] code_o,
  input logic [NCH-1:0]    use_dac_o
);
  a_r6_hold_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_ni) |-> $stable(code_o));

  a_r8_clear_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> (use_dac_o == '0));

  a_r8_clear_blocks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!clr_ni) |-> $stable(code_o));

  a_r9_flag_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((use_dac_o != '0) && ($past(use_dac_o) == '0)) |-> $past(!load_ni && clr_ni));
endmodule

bind dac_loader dac_loader_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .clr_ni    (clr_ni),
  .code_o    (code_o),
  .use_dac_o (use_dac_o)
);

// File: tb/dac_loader_tb_top.sv
module dac_loader_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 14;
  localparam int NV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, bmode = 1'b0, bhi = 1'b0;
  logic [2:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic load_n = 1'b1, clr_n = 1'b1;
  logic [NCH*DW-1:0] code;
  logic [NCH-1:0] use_dac;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
    .byte_mode_i(bmode), .byte_hi_i(bhi), .addr_i(addr), .data_i(data),
    .load_ni(load_n), .clr_ni(clr_n), .code_o(code), .use_dac_o(use_dac)
  );

  // {byte_mode, byte_hi, addr[2:0], data[13:0], check_ch[1:0], expect[13:0]}
  localparam logic [34:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 14'h1234, 2'd0, 14'h1234},  // R2
    {1'b0, 1'b0, 3'd3, 14'h3FFF, 2'd3, 14'h3FFF},  // R2
    {1'b1, 1'b0, 3'd1, 14'h3FAB, 2'd1, 14'h0000},  // R4 low part only
    {1'b1, 1'b1, 3'd1, 14'h3F25, 2'd1, 14'h25AB},  // R4 completes
    {1'b0, 1'b0, 3'd5, 14'h0555, 2'd0, 14'h1234},  // R5
    {1'b0, 1'b0, 3'd4, 14'h0111, 2'd0, 14'h1234},  // R5
    {1'b0, 1'b0, 3'd2, 14'h2AAA, 2'd2, 14'h2AAA},  // R2
    {1'b1, 1'b1, 3'd2, 14'h0011, 2'd2, 14'h1100}   // R4 per-channel stage
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel_n, input logic bm, input logic hi,
                           input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs_n = sel_n; bmode = bm; bhi = hi; addr = a; data = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;           // commit at next posedge
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);        // latch follows one edge later when load is low
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code", code[DW-1:0], '0);
    chk("R1 flags", {10'd0, use_dac}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    load_n = 1'b0;
    @(negedge clk);
    chk("R7 flags", {10'd0, use_dac}, 14'hF);

    // R10: load held low through the walk
    for (int v = 0; v < NV; v++) begin
      bus_write(1'b0, VEC[v][34], VEC[v][33], VEC[v][32:30], VEC[v][29:16]);
      chk("R10 vector", code[VEC[v][15:14]*DW +: DW], VEC[v][13:0]);
    end

    bus_write(1'b1, 1'b0, 1'b0, 3'd0, 14'h0777);
    chk("R3 ignored", code[DW-1:0], 14'h1234);

    load_n = 1'b1;
    bus_write(1'b0, 1'b0, 1'b0, 3'd0, 14'h0ABC);
    @(negedge clk);
    chk("R6 hold", code[DW-1:0], 14'h1234);
    chk("R6 flags", {10'd0, use_dac}, 14'hF);
    load_n = 1'b0;
    @(negedge clk);
    chk("R7 ch0", code[DW-1:0], 14'h0ABC);
    chk("R7 ch3", code[3*DW +: DW], 14'h3FFF);

    clr_n = 1'b0;
    #1;
    chk("R8 async flags", {10'd0, use_dac}, '0);
    bus_write(1'b0, 1'b0, 1'b0, 3'd0, 14'h0321);
    chk("R8 load blocked", code[DW-1:0], 14'h0ABC);
    chk("R8 flags low", {10'd0, use_dac}, '0);
    load_n = 1'b1;
    @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 flags stay", {10'd0, use_dac}, '0);
    load_n = 1'b0;
    @(negedge clk);
    chk("R9 flags back", {10'd0, use_dac}, 14'hF);
    chk("R9 code", code[DW-1:0], 14'h0321);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule